// File: doc/BRIEF.md
# Paged Program Counter with Return Stack

This unit keeps the instruction address of a small microcontroller core. Each cycle is one instruction. With no control strobe the 13-bit address steps up by one. The 13 bits span 8K words, split into four 2K-word pages. Absolute jumps and subroutine calls carry an 11-bit literal, which lands in the low address bits. The two high address bits come from a page-select latch that software writes ahead of the branch.

A call saves the address of the following instruction on an 8-entry hardware stack before it branches. A return takes the complete 13-bit address back off that stack and ignores the latch. The parameter `MEM_WORDS` sets the implemented program memory size, and that size decides which page bits a branch uses. At 2K words or less, branches stay in page 0. At more than 2K and up to 4K words, only the low page bit counts, so addresses 1000h–1FFFh cannot be reached.

The unit does no decoding. It is given one-cycle strobes, the literal, and a write port for the latch. The latch keeps only the two page-select bits of the software register, which sit at bits 4 and 3 of that register. The write port carries those two bits, and port bit 0 is register bit 3.

Top module: `paged_pc_unit`

## Requirements
- R1: While `rst_n` is low, `pc_o` reads 0000h. Reset also clears the page latch and the stack pointer, so a jump made just after reset lands in page 0.
- R2: In a cycle with no strobe, `pc_o` goes up by one at the next clock edge, and 1FFFh is followed by 0000h.
- R3: On `goto_i`, the next `pc_o` is formed from two parts. Bits 10:0 are `lit_i`. Bits 12:11 are the honoured page-latch bits (port bit 0 → address bit 11, port bit 1 → address bit 12), and any page bit that is not honoured is 0.
- R4: On `call_i`, `pc_o` is loaded with the same target as for a jump. The stack saves the current `pc_o` + 1, all 13 bits, wrapping at 1FFFh.
- R5: On `ret_i`, the next `pc_o` is the most recently saved stack entry, all 13 bits. The page latch has no effect on this value.
- R6: A latch write changes nothing in sequential execution, and only the next call or jump sees it. When a call or jump falls in the same cycle as a latch write, it uses the value the latch held before that write.
- R7: When `MEM_WORDS` ≤ 2048, address bits 12:11 are 0 after every call and jump, whatever the latch holds.
- R8: When 2048 < `MEM_WORDS` ≤ 4096, address bit 12 is 0 after every call and jump, and address bit 11 follows page-latch port bit 0.
- R9: The return stack is a circular buffer of 8 entries. A ninth call without a return overwrites the oldest entry. Returns pop in reverse order of the calls, and when the pointer wraps, a pop gives whichever entry it reaches. There are no overflow or underflow flags.
- R10: At most one of `call_i`, `goto_i`, `ret_i` may be high in a cycle. This is a usage rule that the unit checks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with `clk` |
| call_i | input | 1 | Subroutine call strobe |
| goto_i | input | 1 | Absolute jump strobe |
| ret_i | input | 1 | Return strobe |
| lit_i | input | 11 | Branch literal from the instruction word |
| page_we_i | input | 1 | Page-latch write enable |
| page_d_i | input | 2 | Page-select bits to write (register bits 4:3) |
| pc_o | output | 13 | Current program counter |

## Verification
The embedded assertions check these on every cycle:
- the sequential step of one;
- the literal landing in the low address bits;
- the forced page bits when memory is small;
- the latch holding its value when it is not written;
- the stack pointer moving by one on each push and each pop;
- a call followed at once by a return resuming after the call;
- the strobe exclusivity rule.

Other behaviours involve longer histories and need the bench's directed scenarios and its reference model: deep call chains, the ninth-push overwrite, wrap-around pops, the same-cycle latch-write ordering, returns that ignore a changed latch, and the 1FFFh wrap during a call. The bench runs three memory-size configurations side by side.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  typedef enum logic [1:0] {
    OP_SEQ  = 2'd0,
    OP_JUMP = 2'd1,
    OP_CALL = 2'd2,
    OP_RET  = 2'd3
  } pc_op_e;

  // Number of page-select bits that address implemented memory.
  function automatic int honoured_page_bits(input int words, input int lit_w, input int pg_w);
    int n;
    n = 0;
    for (int i = 0; i < pg_w; i++) begin
      if (words > (1 << (lit_w + i))) n = i + 1;
    end
    return n;
  endfunction

endpackage

// File: rtl/pcu_page_latch.sv
module pcu_page_latch #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q_q, q_d;

  always_comb begin
    q_d = q_q;
    if (we_i) q_d = d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end

  assign q_o = q_q;

  // R6: without a write the latch keeps its value
  p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(q_q));

endmodule

// File: rtl/pcu_ret_stack.sv
module pcu_ret_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] push_data_i,
  output logic [W-1:0] top_o
);

  localparam int SP_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [SP_W-1:0] sp_q, sp_d;
  logic [W-1:0]    mem_q [DEPTH];

  // circular pointer: wraps freely in both directions
  always_comb begin
    sp_d = sp_q;
    if (push_i)     sp_d = sp_q + SP_W'(1);
    else if (pop_i) sp_d = sp_q - SP_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= '0;
    else        sp_q <= sp_d;
  end

  // storage has no reset; written only under the push enable
  always_ff @(posedge clk) begin
    if (push_i) mem_q[sp_q] <= push_data_i;
  end

  assign top_o = mem_q[sp_q - SP_W'(1)];

  // R9: a push advances the pointer by one, modulo depth
  p_push_advance_r9: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |=> sp_q == SP_W'($past(sp_q) + SP_W'(1)));

  // R9: a pop retreats the pointer by one, modulo depth
  p_pop_retreat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i) |=> sp_q == SP_W'($past(sp_q) - SP_W'(1)));

  // R10: push and pop never requested together
  p_push_pop_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_i && pop_i));

endmodule

// File: rtl/pcu_target.sv
module pcu_target #(
  parameter int LIT_W = 11,
  parameter int PG_W  = 2,
  parameter int HON   = 2
) (
  input  logic [PG_W-1:0]       page_i,
  input  logic [LIT_W-1:0]      lit_i,
  output logic [LIT_W+PG_W-1:0] tgt_o
);

  assign tgt_o[LIT_W-1:0] = lit_i;

  // each page bit is either taken from the latch or tied low
  for (genvar i = 0; i < PG_W; i++) begin : g_page
    if (i < HON) begin : g_use
      assign tgt_o[LIT_W+i] = page_i[i];
    end else begin : g_zero
      assign tgt_o[LIT_W+i] = 1'b0;
    end
  end

endmodule

// File: rtl/paged_pc_unit.sv
module paged_pc_unit #(
  parameter int PC_W        = 13,
  parameter int LIT_W       = 11,
  parameter int STACK_DEPTH = 8,
  parameter int MEM_WORDS   = 8192
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 call_i,
  input  logic                 goto_i,
  input  logic                 ret_i,
  input  logic [LIT_W-1:0]     lit_i,
  input  logic                 page_we_i,
  input  logic [PC_W-LIT_W-1:0] page_d_i,
  output logic [PC_W-1:0]      pc_o
);

  import pcu_pkg::*;

  localparam int PG_W = PC_W - LIT_W;
  localparam int HON  = honoured_page_bits(MEM_WORDS, LIT_W, PG_W);

  pc_op_e          op;
  logic [PC_W-1:0] pc_q, pc_d;
  logic [PC_W-1:0] pc_inc;
  logic [PC_W-1:0] jump_tgt;
  logic [PC_W-1:0] stack_top;
  logic [PG_W-1:0] page_q;

  // strobe decode
  always_comb begin
    op = OP_SEQ;
    if (call_i)      op = OP_CALL;
    else if (goto_i) op = OP_JUMP;
    else if (ret_i)  op = OP_RET;
  end

  pcu_page_latch #(.W(PG_W)) u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .we_i  (page_we_i),
    .d_i   (page_d_i),
    .q_o   (page_q)
  );

  pcu_target #(.LIT_W(LIT_W), .PG_W(PG_W), .HON(HON)) u_target (
    .page_i (page_q),
    .lit_i  (lit_i),
    .tgt_o  (jump_tgt)
  );

  assign pc_inc = pc_q + PC_W'(1);

  pcu_ret_stack #(.DEPTH(STACK_DEPTH), .W(PC_W)) u_stack (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (op == OP_CALL),
    .pop_i       (op == OP_RET),
    .push_data_i (pc_inc),
    .top_o       (stack_top)
  );

  always_comb begin
    unique case (op)
      OP_CALL, OP_JUMP: pc_d = jump_tgt;
      OP_RET:           pc_d = stack_top;
      default:          pc_d = pc_inc;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  assign pc_o = pc_q;

  // R2: no strobe means a step of one, wrapping at the top
  p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!call_i && !goto_i && !ret_i) |=> pc_q == PC_W'($past(pc_q) + 1));

  // R3: the literal lands in the low address bits on a branch
  p_jump_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i || goto_i) |=> pc_q[LIT_W-1:0] == $past(lit_i));

  // R5: a call followed at once by a return resumes after the call
  p_call_ret_r5: assert property (@(posedge clk) disable iff (!rst_n)
    call_i ##1 ret_i |=> pc_q == PC_W'($past(pc_q, 2) + 1));

  // R10: strobes are mutually exclusive
  p_strobe_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({call_i, goto_i, ret_i}));

  // R7 (no page bit honoured) and R8 (only the low one honoured)
  if (HON < PG_W) begin : g_page_force
    p_page_forced_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (call_i || goto_i) |=> pc_q[PC_W-1:LIT_W+HON] == '0);
  end

endmodule

// File: tb/paged_pc_unit_test.sv
module paged_pc_unit_test;

  logic        clk;
  logic        rst_n;
  logic        call_i, goto_i, ret_i, page_we_i;
  logic [10:0] lit_i;
  logic [1:0]  page_d_i;
  logic [12:0] pc8, pc4, pc2;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  paged_pc_unit #(.MEM_WORDS(8192)) uut (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .goto_i(goto_i), .ret_i(ret_i),
    .lit_i(lit_i), .page_we_i(page_we_i), .page_d_i(page_d_i), .pc_o(pc8));
  paged_pc_unit #(.MEM_WORDS(4096)) uut_4k (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .goto_i(goto_i), .ret_i(ret_i),
    .lit_i(lit_i), .page_we_i(page_we_i), .page_d_i(page_d_i), .pc_o(pc4));
  paged_pc_unit #(.MEM_WORDS(2048)) uut_2k (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .goto_i(goto_i), .ret_i(ret_i),
    .lit_i(lit_i), .page_we_i(page_we_i), .page_d_i(page_d_i), .pc_o(pc2));

  typedef struct packed {
    logic [12:0] e8;
    logic [12:0] e4;
    logic [12:0] e2;
    logic [7:0]  req;
  } item_t;

  item_t       sb_q[$];
  int          checks, errors;
  logic [12:0] m_pc  [3];
  logic [12:0] m_stk [3][8];
  int          m_sp  [3];
  logic [1:0]  m_latch;
  int          hon   [3];
  logic [15:0] lfsr;

  task automatic check(input string what, input int req, input logic [12:0] act, input logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // driver: applies one instruction and queues the expected PCs
  task automatic step(input logic c, input logic g, input logic r, input logic [10:0] lit,
                      input logic we, input logic [1:0] pd, input int req);
    logic [12:0] inc, tgt;
    logic [1:0]  pg;
    item_t       it;
    @(negedge clk);
    call_i = c; goto_i = g; ret_i = r; lit_i = lit; page_we_i = we; page_d_i = pd;
    for (int k = 0; k < 3; k++) begin
      inc = m_pc[k] + 13'd1;
      pg  = m_latch & 2'((1 << hon[k]) - 1);
      tgt = {pg, lit};
      if (c) begin
        m_stk[k][m_sp[k]] = inc;
        m_sp[k] = (m_sp[k] + 1) % 8;
        m_pc[k] = tgt;
      end else if (g) begin
        m_pc[k] = tgt;
      end else if (r) begin
        m_sp[k] = (m_sp[k] + 7) % 8;
        m_pc[k] = m_stk[k][m_sp[k]];
      end else begin
        m_pc[k] = inc;
      end
    end
    if (we) m_latch = pd;
    it.e8 = m_pc[0]; it.e4 = m_pc[1]; it.e2 = m_pc[2]; it.req = 8'(req);
    sb_q.push_back(it);
  endtask

  task automatic idle(input int n, input int req);
    for (int i = 0; i < n; i++) step(0, 0, 0, 11'h0, 0, 2'b00, req);
  endtask

  // monitor: pops one expected item per clock after the edge
  always @(posedge clk) begin
    item_t it;
    #1;
    if (rst_n && sb_q.size() > 0) begin
      it = sb_q.pop_front();
      check("pc 8K", int'(it.req), pc8, it.e8);
      check("pc 4K", int'(it.req), pc4, it.e4);
      check("pc 2K", int'(it.req), pc2, it.e2);
    end
  end

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    join_none
  end

  initial begin
    checks = 0; errors = 0;
    hon[0] = 2; hon[1] = 1; hon[2] = 0;
    for (int k = 0; k < 3; k++) begin m_pc[k] = '0; m_sp[k] = 0; end
    m_latch = 2'b00;
    rst_n = 1'b0;
    call_i = 0; goto_i = 0; ret_i = 0; lit_i = '0; page_we_i = 0; page_d_i = '0;
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    check("reset pc 8K", 1, pc8, 13'h0000);
    check("reset pc 4K", 1, pc4, 13'h0000);
    check("reset pc 2K", 1, pc2, 13'h0000);
    rst_n = 1'b1;

    idle(3, 2);                                   // R2 sequential steps
    step(0, 1, 0, 11'h123, 0, 2'b00, 1);          // R1 latch cleared: page 0
    step(0, 0, 0, 11'h0, 1, 2'b01, 6);            // R6 write only, no effect
    idle(1, 6);
    step(0, 1, 0, 11'h055, 0, 2'b00, 3);          // R3 / R7 page 1 select
    step(0, 1, 0, 11'h7FF, 1, 2'b11, 6);          // R6 same-cycle write uses old
    step(0, 1, 0, 11'h7FF, 0, 2'b00, 8);          // R8 bit 12 forced in 4K
    idle(2, 2);                                   // R2 wrap 1FFF -> 0000
    step(0, 1, 0, 11'h200, 0, 2'b00, 7);          // R7 both page bits ignored
    step(1, 0, 0, 11'h3A0, 0, 2'b00, 4);          // R4 call
    idle(2, 4);
    step(0, 0, 0, 11'h0, 1, 2'b00, 5);            // R5 latch changed before ret
    step(0, 0, 1, 11'h7FF, 0, 2'b00, 5);          // R5 ret ignores latch
    step(0, 1, 0, 11'h7FF, 1, 2'b11, 4);
    step(0, 1, 0, 11'h7FF, 0, 2'b00, 4);          // at 1FFF in 8K
    step(1, 0, 0, 11'h010, 0, 2'b00, 4);          // R4 pushed address wraps
    step(0, 0, 1, 11'h0, 0, 2'b00, 4);
    step(1, 0, 0, 11'h020, 0, 2'b00, 5);          // call then immediate ret
    step(0, 0, 1, 11'h0, 0, 2'b00, 5);
    // R9: nine nested calls, then ten returns (wrap-around pops)
    for (int i = 0; i < 9; i++) begin
      step(1, 0, 0, 11'(i * 16 + 1), 0, 2'b00, 9);
      idle(1, 9);
    end
    for (int i = 0; i < 10; i++) step(0, 0, 1, 11'h0, 0, 2'b00, 9);
    // mixed stimulus, one strobe at most per cycle (R10)
    lfsr = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (lfsr[2:0])
        3'd0:    step(1, 0, 0, lfsr[13:3], lfsr[14], lfsr[15:14], 4);
        3'd1:    step(0, 1, 0, lfsr[13:3], lfsr[14], lfsr[15:14], 3);
        3'd2:    step(0, 0, 1, lfsr[13:3], lfsr[14], lfsr[15:14], 9);
        default: step(0, 0, 0, lfsr[13:3], lfsr[15], lfsr[12:11], 6);
      endcase
    end
    @(negedge clk);
    call_i = 0; goto_i = 0; ret_i = 0; page_we_i = 0;
    while (sb_q.size() > 0) @(posedge clk);
    #2;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule